// File: doc/BRIEF.md
# USB Host Controller Status and Interrupt Core

This block holds the run/stop control, status bits and interrupt line of a full-speed USB host controller. While the schedule runs, the descriptor fetcher shows each descriptor's packet identifier and maximum-length field for one cycle. The core flags descriptors that look corrupted and stops the controller at once. The system-bus interface reports parity errors and aborted bus cycles as one-cycle strobes. The root ports report resume signalling as one-cycle strobes.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. Status bits are cleared by writing ones to them. A low-power reset clears the working state and keeps the suspend and port context, so that a device can still wake the system. On a port resume the block raises a wake request toward power management. When wake is enabled, it also emits a one-cycle system-control interrupt pulse.

Top module: `usb_hc_irq_core`

## Requirements
- R1: A descriptor strobe whose identifier is not 0x69, 0xE1 or 0x2D sets the process-error bit (STAT bit 1, address 1). The three listed identifiers never set it.
- R2: A descriptor strobe whose length field is 1280 or more sets the process-error bit. Lengths of 1279 and below do not set it.
- R3: On a process error, the edge that captures the descriptor also clears run (CMD bit 0, address 0), sets halted and raises `irq`. This happens whatever the interrupt-enable register holds.
- R4: Any of the parity, master-abort or target-abort strobes sets the system-error bit (STAT bit 2) and clears run. It raises `irq`, and that interrupt cannot be masked.
- R5: A port resume while global suspend (CMD bit 1) is set sets STAT bit 0. It drives `irq` only when the resume enable (IEN bit 0, address 2) is set. Without global suspend, STAT bit 0 stays clear.
- R6: A resume on port p sets that port's resume bit (bit 1 at address 4+p) and the wake status (WAKE bit 1, address 3). `wake_req` is high while both the wake status and the wake enable (WAKE bit 0) are set. `sci` pulses for one cycle after each resume seen with the wake enable set.
- R7: STAT bits 0 to 2, WAKE bit 1 and the port resume bits clear when a one is written to them. A hardware set in the same cycle wins over the clear. Writes to halted (STAT bit 3) and to low-speed (port bit 2) have no effect.
- R8: Halted (STAT bit 3 and the `halted` output) is set whenever run is cleared, by an error or by software. It clears when software sets run.
- R9: A low-power reset clears run, the interrupt enable, the wake register, STAT bits 1 and 2, `irq` and `sci`, and it sets halted. It keeps global suspend, STAT bit 0 and each port's enabled (bit 0), resume (bit 1), low-speed (bit 2) and suspend (bit 3) bits.
- R10: Events that arrive in the same cycle all set their own status bits.
- R11: After the main reset, run is 0, halted is 1, all other register bits are 0, and `irq`, `sci` and `wake_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous main reset, active low |
| lp_rst | input | 1 | Synchronous low-power reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| desc_valid | input | 1 | A fetched descriptor is presented |
| desc_pid | input | 8 | Descriptor packet identifier |
| desc_maxlen | input | LENW | Descriptor maximum-length field |
| bus_perr | input | 1 | Bus parity error strobe |
| bus_mabort | input | 1 | Bus master-abort strobe |
| bus_tabort | input | 1 | Bus target-abort strobe |
| port_resume | input | NPORTS | Resume strobe per root port |
| port_ls | input | NPORTS | Low-speed device present per port |
| run | output | 1 | Run/stop state |
| halted | output | 1 | Controller halted |
| irq | output | 1 | Interrupt to the host |
| wake_req | output | 1 | Wake request to power management |
| sci | output | 1 | System-control interrupt pulse |

## Verification
Every cycle, the assertions check that a corrupt descriptor or a bus error leaves run low and the matching status bit and `irq` set one edge later. They also check that halted is always the inverse of run, that a masked resume alone never drives `irq`, and that a low-power reset holds global suspend and the resume status. Only the bench scenarios can show the full identifier and length sweeps, the register read-back after a low-power reset, the write-one-to-clear priority and the `sci` pulse width.

// File: rtl/usb_hc_irq_core.sv
module usb_hc_irq_core #(
  parameter int NPORTS       = 2,
  parameter int LENW         = 11,
  parameter int MAXLEN_LIMIT = 1280,
  parameter int AW           = $clog2(4 + NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_rst,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              desc_valid,
  input  logic [7:0]        desc_pid,
  input  logic [LENW-1:0]   desc_maxlen,
  input  logic              bus_perr,
  input  logic              bus_mabort,
  input  logic              bus_tabort,
  input  logic [NPORTS-1:0] port_resume,
  input  logic [NPORTS-1:0] port_ls,
  output logic              run,
  output logic              halted,
  output logic              irq,
  output logic              wake_req,
  output logic              sci
);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_IEN  = AW'(2);
  localparam logic [AW-1:0] A_WAKE = AW'(3);

  logic run_q, halt_q, gsusp_q, st_res, st_proc, st_sys, ien_q, wen_q, wsts_q;
  logic run_d, halt_d, gsusp_d, st_res_d, st_proc_d, st_sys_d, ien_d, wen_d, wsts_d;
  logic irq_q, sci_q;
  logic [NPORTS-1:0] p_en, p_res, p_ls, p_susp;

  wire pid_ok   = (desc_pid == 8'h69) || (desc_pid == 8'hE1) || (desc_pid == 8'h2D);
  wire len_bad  = 32'(desc_maxlen) >= MAXLEN_LIMIT;
  wire proc_hit = desc_valid && (!pid_ok || len_bad);
  wire sys_hit  = bus_perr || bus_mabort || bus_tabort;
  wire any_res  = |port_resume;
  wire wr_cmd   = reg_we && reg_addr == A_CMD;
  wire wr_stat  = reg_we && reg_addr == A_STAT;
  wire wr_ien   = reg_we && reg_addr == A_IEN;
  wire wr_wake  = reg_we && reg_addr == A_WAKE;

  always_comb begin
    run_d   = wr_cmd ? reg_wdata[0] : run_q;
    if (proc_hit || sys_hit) run_d = 1'b0;
    halt_d  = halt_q;
    if (run_q && !run_d) halt_d = 1'b1;
    if (!run_q && run_d) halt_d = 1'b0;
    gsusp_d   = wr_cmd ? reg_wdata[1] : gsusp_q;
    st_res_d  = (st_res  & ~(wr_stat & reg_wdata[0])) | (any_res & gsusp_q);
    st_proc_d = (st_proc & ~(wr_stat & reg_wdata[1])) | proc_hit;
    st_sys_d  = (st_sys  & ~(wr_stat & reg_wdata[2])) | sys_hit;
    ien_d     = wr_ien ? reg_wdata[0] : ien_q;
    wen_d     = wr_wake ? reg_wdata[0] : wen_q;
    wsts_d    = (wsts_q & ~(wr_wake & reg_wdata[1])) | any_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; halt_q <= 1'b1; gsusp_q <= 1'b0; st_res <= 1'b0;
      st_proc <= 1'b0; st_sys <= 1'b0; ien_q <= 1'b0; wen_q <= 1'b0;
      wsts_q <= 1'b0; irq_q <= 1'b0; sci_q <= 1'b0;
    end else if (lp_rst) begin
      run_q <= 1'b0; halt_q <= 1'b1; st_proc <= 1'b0; st_sys <= 1'b0;
      ien_q <= 1'b0; wen_q <= 1'b0; wsts_q <= 1'b0; irq_q <= 1'b0; sci_q <= 1'b0;
    end else begin
      run_q <= run_d; halt_q <= halt_d; gsusp_q <= gsusp_d; st_res <= st_res_d;
      st_proc <= st_proc_d; st_sys <= st_sys_d; ien_q <= ien_d; wen_q <= wen_d;
      wsts_q <= wsts_d;
      irq_q <= st_proc_d | st_sys_d | (st_res_d & ien_d);
      sci_q <= any_res & wen_q;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    wire wr_p = reg_we && reg_addr == AW'(4 + p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_en[p] <= 1'b0; p_res[p] <= 1'b0; p_ls[p] <= 1'b0; p_susp[p] <= 1'b0;
      end else if (!lp_rst) begin
        if (wr_p) begin
          p_en[p]   <= reg_wdata[0];
          p_susp[p] <= reg_wdata[3];
        end
        p_res[p] <= (p_res[p] & ~(wr_p & reg_wdata[1])) | port_resume[p];
        p_ls[p]  <= port_ls[p];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD:   reg_rdata[1:0] = {gsusp_q, run_q};
      A_STAT:  reg_rdata[3:0] = {halt_q, st_sys, st_proc, st_res};
      A_IEN:   reg_rdata[0]   = ien_q;
      A_WAKE:  reg_rdata[1:0] = {wsts_q, wen_q};
      default:
        for (int p = 0; p < NPORTS; p++)
          if (reg_addr == AW'(4 + p))
            reg_rdata[3:0] = {p_susp[p], p_ls[p], p_res[p], p_en[p]};
    endcase
  end

  assign run      = run_q;
  assign halted   = halt_q;
  assign irq      = irq_q;
  assign sci      = sci_q;
  assign wake_req = wsts_q & wen_q;

  // R3
  proc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_hit && !lp_rst) |=> (!run_q && halt_q && st_proc && irq_q));
  // R4
  sys_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_hit && !lp_rst) |=> (!run_q && st_sys && irq_q));
  // R8
  halt_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q != run_q);
  // R5
  res_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !st_proc && !st_sys) |-> !irq_q);
  // R9
  lp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_rst |=> ($stable(gsusp_q) && $stable(st_res) && !run_q && !irq_q));
  // R6
  sci_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_res && wen_q && !lp_rst) |=> sci_q);
endmodule

// File: tb/usb_hc_irq_core_tb_top.sv
module usb_hc_irq_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int AW = 3;

  logic clk = 0, rst_n = 0, lp_rst = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic desc_valid = 0;
  logic [7:0] desc_pid = '0;
  logic [10:0] desc_maxlen = '0;
  logic bus_perr = 0, bus_mabort = 0, bus_tabort = 0;
  logic [NP-1:0] port_resume = '0, port_ls = '0;
  logic run, halted, irq, wake_req, sci;
  int total = 0, bad = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_hc_irq_core #(.NPORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_valid(desc_valid),
    .desc_pid(desc_pid), .desc_maxlen(desc_maxlen), .bus_perr(bus_perr),
    .bus_mabort(bus_mabort), .bus_tabort(bus_tabort), .port_resume(port_resume),
    .port_ls(port_ls), .run(run), .halted(halted), .irq(irq), .wake_req(wake_req),
    .sci(sci));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = AW'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    reg_addr = AW'(a); #1; d = reg_rdata;
  endtask

  task automatic desc(input int pid, input int len);
    @(negedge clk); desc_valid = 1; desc_pid = 8'(pid); desc_maxlen = 11'(len);
    @(negedge clk); desc_valid = 0;
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 4 + NP; a++) begin
      rd(a, v);
      chk(v == ((a == 1) ? 16'h8 : 16'h0), "R11", v, (a == 1) ? 8 : 0);
    end
    chk({irq, sci, wake_req, run} == 4'b0 && halted, "R11", {irq, sci, wake_req, run, halted}, 1);

    // R8 halted follows run
    wr(1, 16'h8);
    rd(1, v); chk(v[3] == 1, "R8", v, 8);
    wr(0, 1);
    rd(1, v); chk(v[3] == 0 && !halted && run, "R8", v, 0);
    wr(0, 0);
    rd(1, v); chk(v[3] == 1 && halted && !run, "R8", v, 8);

    // R1 R3 identifier sweep with interrupts disabled
    for (int pid = 0; pid < 256; pid++) begin
      bit e;
      e = !(pid == 'h69 || pid == 'hE1 || pid == 'h2D);
      wr(0, 1);
      desc(pid, 64);
      rd(1, v);
      chk(v[1] == e, "R1", v[1], e);
      chk(irq == e && run == !e && halted == e, "R3", {irq, run, halted}, {e, !e, e});
      wr(1, 7);
    end

    // R2 length boundary
    for (int len = 1270; len <= 1290; len++) begin
      bit e;
      e = (len >= 1280);
      wr(0, 1);
      desc('hE1, len);
      rd(1, v); chk(v[1] == e && irq == e, "R2", {v[1], irq}, {e, e});
      wr(1, 7);
    end
    wr(0, 1); desc('h2D, 2047);
    rd(1, v); chk(v[1] == 1 && !run, "R2", v, 2); wr(1, 7);

    // R4 bus error strobe combinations
    for (int m = 0; m < 8; m++) begin
      bit e;
      e = (m != 0);
      wr(0, 1);
      @(negedge clk); {bus_perr, bus_mabort, bus_tabort} = 3'(m);
      @(negedge clk); {bus_perr, bus_mabort, bus_tabort} = 3'b0;
      rd(1, v);
      chk(v[2] == e && irq == e && run == !e && halted == e, "R4", {v[2], irq, run}, {e, e, !e});
      wr(1, 7);
    end

    // R5 R6 resume sweep
    for (int gs = 0; gs < 2; gs++)
      for (int ie = 0; ie < 2; ie++)
        for (int we = 0; we < 2; we++)
          for (int p = 0; p < NP; p++) begin
            wr(0, gs << 1); wr(2, ie); wr(3, we | 2); wr(1, 7); wr(4 + p, 2);
            chk(!wake_req && !irq, "R6", {wake_req, irq}, 0);
            @(negedge clk); port_resume[p] = 1;
            @(negedge clk); port_resume = '0;
            chk(sci == we, "R6", sci, we);
            chk(irq == (gs & ie), "R5", irq, gs & ie);
            rd(1, v); chk(v[0] == gs, "R5", v[0], gs);
            rd(4 + p, v); chk(v[1] == 1, "R6", v, 2);
            rd(3, v); chk(v[1] == 1 && wake_req == we, "R6", {v[1], wake_req}, {1'b1, we[0]});
            @(negedge clk);
            chk(sci == 0, "R6", sci, 0);
          end
    wr(0, 0); wr(2, 0); wr(3, 2); wr(1, 7); wr(4, 2); wr(5, 2);

    // R10 simultaneous events
    wr(0, 3);
    @(negedge clk); desc_valid = 1; desc_pid = 8'h00; desc_maxlen = '0; bus_perr = 1; port_resume = 2'b01;
    @(negedge clk); desc_valid = 0; bus_perr = 0; port_resume = '0;
    rd(1, v); chk(v[2:0] == 3'b111, "R10", v[2:0], 7);

    // R7 clear vs set priority and selective clear
    @(negedge clk); reg_we = 1; reg_addr = 1; reg_wdata = 16'h2; desc_valid = 1;
    @(negedge clk); reg_we = 0; desc_valid = 0;
    rd(1, v); chk(v[2:0] == 3'b111, "R7", v[2:0], 7);
    wr(1, 2);
    rd(1, v); chk(v[2:0] == 3'b101, "R7", v[2:0], 5);
    wr(1, 5);
    rd(1, v); chk(v[2:0] == 3'b000 && !irq, "R7", v, 8);
    port_ls = 2'b10; wr(5, 16'h4);
    rd(5, v); chk(v[3:0] == 4'b0100, "R7", v, 4);
    wr(5, 16'h0); port_ls = '0; wr(4, 2); wr(5, 2); wr(3, 2);

    // R9 low-power reset retention
    wr(0, 3); wr(2, 1); wr(3, 1); wr(4, 9); port_ls = 2'b01;
    @(negedge clk); port_resume = 2'b01;
    @(negedge clk); port_resume = '0;
    chk(irq == 1 && wake_req == 1, "R9", {irq, wake_req}, 3);
    @(negedge clk); lp_rst = 1; port_ls = '0;
    @(negedge clk); lp_rst = 0;
    rd(0, v); chk(v[1:0] == 2'b10, "R9", v, 2);
    rd(1, v); chk(v[3:0] == 4'b1001, "R9", v, 9);
    rd(4, v); chk(v[3:0] == 4'b1111, "R9", v, 15);
    rd(2, v); chk(v == 0, "R9", v, 0);
    rd(3, v); chk(v == 0, "R9", v, 0);
    chk(!irq && !sci && !wake_req && !run && halted, "R9", {irq, sci, wake_req, run, halted}, 1);

    finish_up();
  end
endmodule